// File: doc/BRIEF.md
# Mixed Indexed/Direct Pixel Selector

This block streams the pixels of one frame out of a three-plane framebuffer. Each pixel position owns an 8-bit palette index, a 32-bit direct-color word and a 32-bit control word. On every pixel the block decides whether the output color comes from the palette or from the direct word. The decision is taken per pixel, from the top byte of that pixel's control word. The result leaves on a valid/ready stream as 24-bit RGB, with a start-of-line flag and an end-of-frame flag.

A raster walker forms one shared word address for all three planes. The line pitch is fixed and does not depend on the active width. The planes sit in synchronous memories, and the palette is an external lookup port. Both have one cycle of read latency and must hold their read data while their enable is low. A frame begins on a start pulse. The active width and height are taken from configuration inputs at that moment.

The stream obeys back-pressure. While `out_ready` is low, a presented pixel stays on the port unchanged. The whole pipeline, including the memory and palette reads, freezes with it, so no pixel is dropped or repeated.

Top module: `pxsel_mixed`

## Requirements
- R1: A pixel whose control word has bits 31:24 equal to 0x03 is a direct pixel. Any other value in that byte, 0x02 included, gives the palette color for that pixel's index byte.
- R2: For a direct pixel, `out_rgb` takes red = direct word bits 7:0, green = bits 15:8 and blue = bits 23:16. Direct word bits 31:24 have no effect. `out_rgb` packs red in 23:16, green in 15:8 and blue in 7:0.
- R3: The fetch address is y*1024 + x, with x in bits 9:0 and y in bits 19:10. Pixels are fetched with x running fastest, and x never reaches the active width.
- R4: After reset the block is idle. A start pulse while idle begins a frame. A start pulse during a frame has no effect. No pixel is output after the end-of-frame pixel until the next start.
- R5: `out_sol` is high exactly on pixels with x = 0. `out_eof` is high exactly on the last pixel of the last line. Neither flag is ever high without `out_valid`.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_rgb`, `out_sol` and `out_eof` hold their values on the next cycle.
- R7: Width and height are captured at the start pulse, and a frame delivers exactly width*height pixels. Changes on the configuration inputs during a frame have no effect.
- R8: During and right after reset, `out_valid`, `fetch_en` and the flags are low.
- R9: `pal_idx` carries the index-plane byte one cycle after its fetch. The palette color is used one cycle later. `pal_en` is high whenever `fetch_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Frame start pulse, honoured only when idle |
| cfg_width | input | 11 | Active width, 1 to 1024 |
| cfg_height | input | 10 | Active height, 1 to 768 |
| fetch_en | output | 1 | Read enable for the three plane memories |
| fetch_addr | output | 20 | Word address shared by all planes |
| idx_data | input | 8 | Index-plane byte, one cycle after fetch |
| dir_data | input | 32 | Direct-plane word, one cycle after fetch |
| ctl_data | input | 32 | Control-plane word, one cycle after fetch |
| pal_en | output | 1 | Palette lookup enable |
| pal_idx | output | 8 | Palette lookup index |
| pal_rgb | input | 24 | Palette color, one cycle after lookup |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_rgb | output | 24 | Output pixel color {R,G,B} |
| out_sol | output | 1 | First pixel of a line |
| out_eof | output | 1 | Last pixel of the frame |

## Verification
The checker watches four things on every cycle. Outputs must hold steady under a stall. The line and frame flags must never appear without valid. Fetch addresses must step by one inside a line and stay inside the allowed height. A fetch must always come with a palette enable. Whether each color comes from the right source with the right byte order, whether the flags sit on the right pixels, and whether a start pulse or configuration change in the middle of a frame is ignored, only the bench's scoreboard can show. It does so by comparing every delivered pixel against a model across frames of several shapes, with random back-pressure and with control bytes 0x02 and 0x03 on neighbouring pixels.

// File: rtl/pxsel_pkg.sv
package pxsel_pkg;
  localparam logic [7:0] DIRECT_TAG = 8'h03;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  // Big-endian word: byte1 (23:16) blue, byte2 (15:8) green, byte3 (7:0) red.
  function automatic rgb_t direct_to_rgb(logic [31:0] w);
    rgb_t c;
    c.r = w[7:0];
    c.g = w[15:8];
    c.b = w[23:16];
    return c;
  endfunction
endpackage

// File: rtl/pxsel_raster.sv
module pxsel_raster #(
  parameter int MAX_W = 1024,
  parameter int MAX_H = 768,
  localparam int XW = $clog2(MAX_W),
  localparam int YW = $clog2(MAX_H),
  localparam int AW = XW + YW,
  localparam int WW = $clog2(MAX_W + 1),
  localparam int HW = $clog2(MAX_H + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [WW-1:0] cfg_w,
  input  logic [HW-1:0] cfg_h,
  input  logic          adv,
  output logic          fetch_en,
  output logic [AW-1:0] fetch_addr,
  output logic          fetch_sol,
  output logic          fetch_eof
);
  logic          busy;
  logic [XW-1:0] x;
  logic [YW-1:0] y;
  logic [WW-1:0] w_q;
  logic [HW-1:0] h_q;
  logic          last_x, last_y;

  assign last_x = (WW'(x) == w_q - WW'(1));
  assign last_y = (HW'(y) == h_q - HW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      x    <= '0;
      y    <= '0;
      w_q  <= WW'(1);
      h_q  <= HW'(1);
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        x    <= '0;
        y    <= '0;
        w_q  <= cfg_w;
        h_q  <= cfg_h;
      end
    end else if (adv) begin
      if (last_x) begin
        x <= '0;
        if (last_y) busy <= 1'b0;
        else        y    <= y + YW'(1);
      end else begin
        x <= x + XW'(1);
      end
    end
  end

  // Line pitch is 2**XW words regardless of the active width.
  assign fetch_en   = busy & adv;
  assign fetch_addr = {y, x};
  assign fetch_sol  = (x == '0);
  assign fetch_eof  = last_x & last_y;
endmodule

// File: rtl/pxsel_align.sv
module pxsel_align
  import pxsel_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        adv,
  input  logic        fetch_en,
  input  logic        fetch_sol,
  input  logic        fetch_eof,
  input  logic [31:0] ctl_data,
  input  logic [31:0] dir_data,
  output logic        s2_valid,
  output logic        s2_sol,
  output logic        s2_eof,
  output logic        s2_direct,
  output rgb_t        s2_rgb
);
  logic s1_valid, s1_sol, s1_eof;

  // Stage 1: plane data returns; stage 2: palette data returns.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_sol    <= 1'b0;
      s1_eof    <= 1'b0;
      s2_valid  <= 1'b0;
      s2_sol    <= 1'b0;
      s2_eof    <= 1'b0;
      s2_direct <= 1'b0;
      s2_rgb    <= '0;
    end else if (adv) begin
      s1_valid  <= fetch_en;
      s1_sol    <= fetch_en & fetch_sol;
      s1_eof    <= fetch_en & fetch_eof;
      s2_valid  <= s1_valid;
      s2_sol    <= s1_sol;
      s2_eof    <= s1_eof;
      s2_direct <= (ctl_data[31:24] == DIRECT_TAG);
      s2_rgb    <= direct_to_rgb(dir_data);
    end
  end
endmodule

// File: rtl/pxsel_merge.sv
module pxsel_merge
  import pxsel_pkg::*;
(
  input  logic        s2_valid,
  input  logic        s2_sol,
  input  logic        s2_eof,
  input  logic        s2_direct,
  input  rgb_t        s2_rgb,
  input  logic [23:0] pal_rgb,
  output logic        out_valid,
  output logic [23:0] out_rgb,
  output logic        out_sol,
  output logic        out_eof
);
  assign out_valid = s2_valid;
  assign out_sol   = s2_valid & s2_sol;
  assign out_eof   = s2_valid & s2_eof;
  assign out_rgb   = s2_direct ? 24'(s2_rgb) : pal_rgb;
endmodule

// File: rtl/pxsel_mixed.sv
module pxsel_mixed
  import pxsel_pkg::*;
#(
  parameter int MAX_W = 1024,
  parameter int MAX_H = 768,
  localparam int XW = $clog2(MAX_W),
  localparam int YW = $clog2(MAX_H),
  localparam int AW = XW + YW,
  localparam int WW = $clog2(MAX_W + 1),
  localparam int HW = $clog2(MAX_H + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [WW-1:0] cfg_width,
  input  logic [HW-1:0] cfg_height,
  output logic          fetch_en,
  output logic [AW-1:0] fetch_addr,
  input  logic [7:0]    idx_data,
  input  logic [31:0]   dir_data,
  input  logic [31:0]   ctl_data,
  output logic          pal_en,
  output logic [7:0]    pal_idx,
  input  logic [23:0]   pal_rgb,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [23:0]   out_rgb,
  output logic          out_sol,
  output logic          out_eof
);
  logic adv;
  logic fetch_sol, fetch_eof;
  logic s2_valid, s2_sol, s2_eof, s2_direct;
  rgb_t s2_rgb;

  // Whole pipeline moves together; memories and palette hold when disabled.
  assign adv     = ~s2_valid | out_ready;
  assign pal_en  = adv;
  assign pal_idx = idx_data;

  pxsel_raster #(.MAX_W(MAX_W), .MAX_H(MAX_H)) raster_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_w(cfg_width), .cfg_h(cfg_height), .adv(adv),
    .fetch_en(fetch_en), .fetch_addr(fetch_addr),
    .fetch_sol(fetch_sol), .fetch_eof(fetch_eof)
  );

  pxsel_align align_i (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .fetch_en(fetch_en), .fetch_sol(fetch_sol), .fetch_eof(fetch_eof),
    .ctl_data(ctl_data), .dir_data(dir_data),
    .s2_valid(s2_valid), .s2_sol(s2_sol), .s2_eof(s2_eof),
    .s2_direct(s2_direct), .s2_rgb(s2_rgb)
  );

  pxsel_merge merge_i (
    .s2_valid(s2_valid), .s2_sol(s2_sol), .s2_eof(s2_eof),
    .s2_direct(s2_direct), .s2_rgb(s2_rgb), .pal_rgb(pal_rgb),
    .out_valid(out_valid), .out_rgb(out_rgb),
    .out_sol(out_sol), .out_eof(out_eof)
  );
endmodule

// File: rtl/pxsel_mixed_chk.sv
module pxsel_mixed_chk #(
  parameter int XW = 10,
  parameter int AW = 20,
  parameter int MAX_H = 768
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fetch_en,
  input logic [AW-1:0] fetch_addr,
  input logic          pal_en,
  input logic          out_valid,
  input logic          out_ready,
  input logic [23:0]   out_rgb,
  input logic          out_sol,
  input logic          out_eof
);
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rgb) && $stable(out_sol) && $stable(out_eof));

  p_flags_need_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sol || out_eof) |-> out_valid);

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en && $past(fetch_en) && (fetch_addr[XW-1:0] != '0) |-> fetch_addr == $past(fetch_addr) + AW'(1));

  p_addr_height_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |-> int'(fetch_addr[AW-1:XW]) < MAX_H);

  p_pal_with_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |-> pal_en);
endmodule

bind pxsel_mixed pxsel_mixed_chk #(.XW(XW), .AW(AW), .MAX_H(MAX_H)) chk_i (
  .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .fetch_addr(fetch_addr),
  .pal_en(pal_en), .out_valid(out_valid), .out_ready(out_ready),
  .out_rgb(out_rgb), .out_sol(out_sol), .out_eof(out_eof)
);

// File: tb/pxsel_mixed_tb_top.sv
`timescale 1ns/1ps
module pxsel_mixed_tb_top;
  localparam int XW = 10, AW = 20, WW = 11, HW = 10;

  typedef struct packed {
    logic        direct;
    logic        sol;
    logic        eof;
    logic [23:0] rgb;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [WW-1:0] cfg_width = WW'(1);
  logic [HW-1:0] cfg_height = HW'(1);
  logic          fetch_en, pal_en, out_valid, out_sol, out_eof;
  logic [AW-1:0] fetch_addr;
  logic [7:0]    idx_data = '0, pal_idx;
  logic [31:0]   dir_data = '0, ctl_data = '0;
  logic [23:0]   pal_rgb = '0, out_rgb;
  logic          out_ready = 1'b0;

  pxsel_mixed dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_width(cfg_width), .cfg_height(cfg_height),
    .fetch_en(fetch_en), .fetch_addr(fetch_addr),
    .idx_data(idx_data), .dir_data(dir_data), .ctl_data(ctl_data),
    .pal_en(pal_en), .pal_idx(pal_idx), .pal_rgb(pal_rgb),
    .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb),
    .out_sol(out_sol), .out_eof(out_eof)
  );

  int checks = 0, errors = 0;
  int seed_v = 0, frame_w = 1, frame_h = 1, rdy_mode = 0, rx_count = 0;
  logic [15:0] lfsr = 16'hACE1;
  exp_t exp_q[$];

  function automatic logic [7:0] f_idx(int a);
    return 8'(a) ^ 8'(a >> 10) ^ 8'(seed_v);
  endfunction
  function automatic logic [31:0] f_ctl(int a);
    logic [7:0] t;
    case ((a + seed_v) % 4)
      0: t = 8'h03;
      1: t = 8'h02;
      2: t = (((a >> 4) & 1) != 0) ? 8'h03 : 8'h00;
      default: t = (((a >> 2) & 1) != 0) ? 8'h02 : 8'h03;
    endcase
    return {t, 8'(a) ^ 8'h3C, 16'h0303};
  endfunction
  function automatic logic [31:0] f_dir(int a);
    return {8'hFF ^ 8'(a), 8'(a) + 8'h11, 8'(a >> 8) ^ 8'h66, 8'(a) ^ 8'(seed_v * 7)};
  endfunction
  function automatic logic [23:0] f_pal(logic [7:0] i);
    return {i ^ 8'h0F, ~i, i + 8'h40};
  endfunction

  // Plane memories and palette: one-cycle read, hold when disabled.
  always @(posedge clk) begin
    if (fetch_en) begin
      idx_data <= f_idx(int'(fetch_addr));
      ctl_data <= f_ctl(int'(fetch_addr));
      dir_data <= f_dir(int'(fetch_addr));
    end
    if (pal_en) pal_rgb <= f_pal(pal_idx);
  end

  // R3: fetch address stays inside the active window.
  always @(negedge clk) begin
    if (rst_n && fetch_en) begin
      checks++;
      if (int'(fetch_addr[XW-1:0]) >= frame_w || int'(fetch_addr[AW-1:XW]) >= frame_h) begin
        errors++;
        $display("FAIL R3 fetch address out of window: actual %h expected x<%0d y<%0d",
                 fetch_addr, frame_w, frame_h);
      end
    end
  end

  // Monitor: drives ready, checks stalls and pops the scoreboard.
  logic        hold_pending = 1'b0;
  logic [25:0] hold_val;
  always @(negedge clk) begin
    if (rdy_mode == 0) out_ready = 1'b1;
    else begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = lfsr[0] | lfsr[5];
    end
    if (rst_n) begin
      if (hold_pending) begin
        checks++;
        if (!out_valid || {out_sol, out_eof, out_rgb} != hold_val) begin
          errors++;
          $display("FAIL R6 stall not held: actual v=%b %h expected v=1 %h",
                   out_valid, {out_sol, out_eof, out_rgb}, hold_val);
        end
        hold_pending = 1'b0;
      end
      if (out_valid && !out_ready) begin
        hold_pending = 1'b1;
        hold_val = {out_sol, out_eof, out_rgb};
      end
      if (out_valid && out_ready) begin
        rx_count++;
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R4 pixel with no frame pending: actual %h expected none", out_rgb);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (out_rgb != e.rgb) begin
            errors++;
            if (e.direct)
              $display("FAIL R2 direct color: actual %h expected %h", out_rgb, e.rgb);
            else
              $display("FAIL R1 R9 palette color: actual %h expected %h", out_rgb, e.rgb);
          end else if (out_sol != e.sol || out_eof != e.eof) begin
            errors++;
            $display("FAIL R5 flags sol/eof: actual %b%b expected %b%b",
                     out_sol, out_eof, e.sol, e.eof);
          end
        end
      end
    end
  end

  task automatic push_frame(int w, int h);
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < w; x++) begin
        int a;
        exp_t e;
        logic [31:0] c, d;
        a = y * 1024 + x;
        c = f_ctl(a);
        d = f_dir(a);
        e.direct = (c[31:24] == 8'h03);
        e.rgb = e.direct ? {d[7:0], d[15:8], d[23:16]} : f_pal(f_idx(a));
        e.sol = (x == 0);
        e.eof = (x == w - 1) && (y == h - 1);
        exp_q.push_back(e);
      end
    end
  endtask

  task automatic run_frame(int w, int h, int seed, int mode, bit inject);
    bit idle_bad;
    seed_v = seed; frame_w = w; frame_h = h; rdy_mode = mode; rx_count = 0;
    push_frame(w, h);
    @(negedge clk);
    cfg_width = WW'(w); cfg_height = HW'(h); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      // R4 R7: restart attempt and new configuration in mid-frame.
      repeat (20) @(negedge clk);
      cfg_width = WW'(w + 3); cfg_height = HW'(h + 1); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    idle_bad = 1'b0;
    repeat (20) begin
      @(negedge clk);
      idle_bad |= out_valid;
    end
    checks++;
    if (idle_bad) begin
      errors++;
      $display("FAIL R4 output after end of frame: actual valid expected idle");
    end
    checks++;
    if (rx_count != w * h) begin
      errors++;
      $display("FAIL R7 pixel count: actual %0d expected %0d", rx_count, w * h);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid || fetch_en || out_sol || out_eof) begin
      errors++;
      $display("FAIL R8 in reset: actual v=%b f=%b expected 0 0", out_valid, fetch_en);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    checks++;
    if (out_valid || fetch_en) begin
      errors++;
      $display("FAIL R8 after reset: actual v=%b f=%b expected 0 0", out_valid, fetch_en);
    end
    run_frame(8, 3, 1, 0, 1'b0);      // R1 R2 R5 basic mix, no stalls
    run_frame(16, 4, 2, 1, 1'b1);     // R4 R6 R7 stalls plus mid-frame start
    run_frame(1, 1, 4, 1, 1'b0);      // R5 single pixel: sol and eof together
    run_frame(1024, 2, 3, 1, 1'b0);   // R3 full-width lines
    run_frame(3, 768, 5, 0, 1'b0);    // R3 full height
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired: actual hang expected frame completion");
    summary();
    $finish;
  end
endmodule